// File: doc/BRIEF.md
# Splittable Up-Counter with Guarded State Registers

This block holds a counter that runs either as a single 32-bit counter or as two independent 16-bit halves, low and high. A mode bit in a configuration word selects between the two. Each half has its own state variable, its own halt bit and its own increment-enable input. A half that is enabled and not halted counts up by one per clock. When it reaches its limit it returns to zero and raises a one-cycle cycle-start pulse that downstream logic can use.

Software reaches the block through a simple word-addressed register port with byte strobes and a registered response, so each half can be written alone. Reads are always allowed and have no side effects. Writes are guarded. A counter write that touches a running half is refused and answered with an error. The same applies to a state write that touches a half that is not halted. A refused access changes nothing.

Top module: `splitcnt_top`

## Requirements
- R1: After reset the counter and state words read 0, both halt bits are 1, the mode bit is 0 (split), and no response or cycle-start pulse is pending.
- R2: In split mode (mode bit 0), the low half counts in bits [15:0] and the high half counts in bits [31:16]. Each counts only while its enable input is 1 and its halt bit is 0. Each returns to 0 after reaching its own 16-bit limit input, so its period is limit+1 cycles, and it pulses its own cycle-start output for one cycle on each return. The halves do not influence each other.
- R3: In unified mode (mode bit 1), the 32-bit word counts as one counter, with carry from bit 15 into bit 16. It is governed by the low halt bit and the low enable input. It returns to 0 after reaching {limitHi, limitLo} and pulses only the low cycle-start output.
- R4: Counter writes follow the byte strobes: bytes 0-1 belong to the low half and bytes 2-3 to the high half. A halted half can be written alone, in part, or together with the other half in one access.
- R5: A counter write is refused with respErr=1, and neither half changes, if any addressed half is running. In unified mode any strobe counts as addressing the low half.
- R6: A state write is accepted only for halves whose halt bit is 1. If any addressed half is not halted, respErr=1 and the state word is unchanged.
- R7: In unified mode the high state field reads as 0. Writes to it are dropped without an error, and its stored value reappears when split mode returns.
- R8: Reads never return an error and change nothing. Word address 3 reads 0, and writes to it are accepted and ignored.
- R9: Every request is answered by respValid exactly one cycle later. The register map by word address is: 0 = configuration (bit 0 mode, bit 8 low halt, bit 9 high halt), 1 = counter, 2 = state. Configuration writes are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Word address |
| busWdata | input | 32 | Write data |
| busStrb | input | 4 | Byte write strobes |
| respValid | output | 1 | Response valid, one cycle after request |
| respErr | output | 1 | Write refused |
| respRdata | output | 32 | Read data |
| enLo | input | 1 | Increment enable, low half or unified counter |
| enHi | input | 1 | Increment enable, high half |
| limitLo | input | 16 | Wrap limit, low half / low bits of unified limit |
| limitHi | input | 16 | Wrap limit, high half / high bits of unified limit |
| cycStartLo | output | 1 | One-cycle pulse after low or unified wrap |
| cycStartHi | output | 1 | One-cycle pulse after high-half wrap |

## Verification
The hardest case to reach from the ports is a mixed access in which one addressed half is halted and the other is running. That access must be refused as a whole, and the halted half must keep its old value too. The stimulus halts only the low half and leaves the high half released with its enable held at 0, so the counter value stays fixed and can be read back exactly after each refused write. Carry across the half boundary in unified mode is reached by preloading the counter just below 0x10000 and letting it run for only a few cycles.

// File: rtl/splitcnt_pkg.sv
package splitcnt_pkg;
  localparam int HALF_W     = 16;
  localparam int DATA_W     = 2 * HALF_W;
  localparam int LANES      = DATA_W / 8;
  localparam int HALF_LANES = LANES / 2;

  // strobes from control to datapath
  typedef struct packed {
    logic              joined;
    logic              haltLo;
    logic              haltHi;
    logic [LANES-1:0]  cntWrByte;
    logic [LANES-1:0]  stWrByte;
    logic [DATA_W-1:0] wdata;
  } dpCmd_t;
endpackage

// File: rtl/splitcnt_ctrl.sv
module splitcnt_ctrl
  import splitcnt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [LANES-1:0]  busStrb,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] state,
  output dpCmd_t            cmd,
  output logic              respValid,
  output logic              respErr,
  output logic [DATA_W-1:0] respRdata
);
  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ST  = ADDR_W'(2);

  logic joinedQ, haltLoQ, haltHiQ;
  logic wrReq, isCfg, isCnt, isSt;
  logic [HALF_LANES-1:0] loLanes, hiLanes, hiStLanes;
  logic touchLo, touchHi, cntErr, stErr, accErr;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    wrReq     = busValid && busWrite;
    isCfg     = busAddr == ADDR_CFG;
    isCnt     = busAddr == ADDR_CNT;
    isSt      = busAddr == ADDR_ST;
    loLanes   = busStrb[HALF_LANES-1:0];
    hiLanes   = busStrb[LANES-1:HALF_LANES];
    hiStLanes = joinedQ ? '0 : hiLanes;
    touchLo   = (|loLanes) || (joinedQ && (|hiLanes));
    touchHi   = !joinedQ && (|hiLanes);
    cntErr    = isCnt && ((touchLo && !haltLoQ) || (touchHi && !haltHiQ));
    stErr     = isSt && (((|loLanes) && !haltLoQ) || ((|hiStLanes) && !haltHiQ));
    accErr    = wrReq && (cntErr || stErr);

    cmd.joined    = joinedQ;
    cmd.haltLo    = haltLoQ;
    cmd.haltHi    = haltHiQ;
    cmd.wdata     = busWdata;
    cmd.cntWrByte = (wrReq && isCnt && !cntErr) ? busStrb : '0;
    cmd.stWrByte  = (wrReq && isSt && !stErr) ? {hiStLanes, loLanes} : '0;
  end

  always_comb begin
    rdMux = '0;
    if (isCfg) begin
      rdMux[0] = joinedQ;
      rdMux[8] = haltLoQ;
      rdMux[9] = haltHiQ;
    end else if (isCnt) begin
      rdMux = count;
    end else if (isSt) begin
      rdMux = joinedQ ? {{HALF_W{1'b0}}, state[HALF_W-1:0]} : state;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      joinedQ   <= 1'b0;
      haltLoQ   <= 1'b1;
      haltHiQ   <= 1'b1;
      respValid <= 1'b0;
      respErr   <= 1'b0;
      respRdata <= '0;
    end else begin
      if (wrReq && isCfg) begin
        if (busStrb[0]) joinedQ <= busWdata[0];
        if (busStrb[1]) begin
          haltLoQ <= busWdata[8];
          haltHiQ <= busWdata[9];
        end
      end
      respValid <= busValid;
      respErr   <= accErr;
      respRdata <= (busValid && !busWrite) ? rdMux : '0;
    end
  end

  a_r9_resp_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> respValid);
  a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !respValid);
  a_r8_read_never_errs: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> !respErr);
  a_r5_refused_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (cmd.cntWrByte == '0 && cmd.stWrByte == '0));
endmodule

// File: rtl/splitcnt_dp.sv
module splitcnt_dp
  import splitcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              enLo,
  input  logic              enHi,
  input  logic [HALF_W-1:0] limitLo,
  input  logic [HALF_W-1:0] limitHi,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] state,
  output logic              cycStartLo,
  output logic              cycStartHi
);
  logic [DATA_W-1:0] cMask, sMask, cntQ, stQ, cntNext, cntWritten;
  logic runLo, runHi, wrapLo, wrapHi, wrLo, wrHi;
  logic [HALF_W-1:0] loNext, hiNext;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_mask
    assign cMask[lane*8 +: 8] = {8{cmd.cntWrByte[lane]}};
    assign sMask[lane*8 +: 8] = {8{cmd.stWrByte[lane]}};
  end

  always_comb begin
    runLo      = !cmd.haltLo && enLo;
    runHi      = !cmd.haltHi && enHi && !cmd.joined;
    wrLo       = |cmd.cntWrByte[HALF_LANES-1:0];
    wrHi       = |cmd.cntWrByte[LANES-1:HALF_LANES];
    cntWritten = (cntQ & ~cMask) | (cmd.wdata & cMask);
    wrapLo     = 1'b0;
    wrapHi     = 1'b0;
    loNext     = cntQ[HALF_W-1:0];
    hiNext     = cntQ[DATA_W-1:HALF_W];
    if (cmd.joined) begin
      cntNext = cntQ;
      if (wrLo || wrHi) begin
        cntNext = cntWritten;
      end else if (runLo) begin
        wrapLo  = cntQ == {limitHi, limitLo};
        cntNext = wrapLo ? '0 : cntQ + 1'b1;
      end
    end else begin
      if (wrLo) begin
        loNext = cntWritten[HALF_W-1:0];
      end else if (runLo) begin
        wrapLo = cntQ[HALF_W-1:0] == limitLo;
        loNext = wrapLo ? '0 : cntQ[HALF_W-1:0] + 1'b1;
      end
      if (wrHi) begin
        hiNext = cntWritten[DATA_W-1:HALF_W];
      end else if (runHi) begin
        wrapHi = cntQ[DATA_W-1:HALF_W] == limitHi;
        hiNext = wrapHi ? '0 : cntQ[DATA_W-1:HALF_W] + 1'b1;
      end
      cntNext = {hiNext, loNext};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ       <= '0;
      stQ        <= '0;
      cycStartLo <= 1'b0;
      cycStartHi <= 1'b0;
    end else begin
      cntQ       <= cntNext;
      stQ        <= (stQ & ~sMask) | (cmd.wdata & sMask);
      cycStartLo <= wrapLo;
      cycStartHi <= wrapHi;
    end
  end

  assign count = cntQ;
  assign state = stQ;

  a_r5_lo_write_only_halted: assert property (@(posedge clk) disable iff (!rstN)
    (|cmd.cntWrByte[HALF_LANES-1:0]) |-> cmd.haltLo);
  a_r6_state_lo_only_halted: assert property (@(posedge clk) disable iff (!rstN)
    (|cmd.stWrByte[HALF_LANES-1:0]) |-> cmd.haltLo);
  a_r2_pulse_after_wrap: assert property (@(posedge clk) disable iff (!rstN)
    cycStartLo |-> (count[HALF_W-1:0] == '0));
  a_r2_halted_lo_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.haltLo && !(|cmd.cntWrByte[HALF_LANES-1:0])) |=> $stable(count[HALF_W-1:0]));
  a_r3_joined_hi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.joined && $past(cmd.joined)) |-> !cycStartHi);
endmodule

// File: rtl/splitcnt_top.sv
module splitcnt_top
  import splitcnt_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [LANES-1:0]  busStrb,
  output logic              respValid,
  output logic              respErr,
  output logic [DATA_W-1:0] respRdata,
  input  logic              enLo,
  input  logic              enHi,
  input  logic [HALF_W-1:0] limitLo,
  input  logic [HALF_W-1:0] limitHi,
  output logic              cycStartLo,
  output logic              cycStartHi
);
  dpCmd_t cmd;
  logic [DATA_W-1:0] count, state;

  splitcnt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busStrb(busStrb),
    .count(count), .state(state), .cmd(cmd),
    .respValid(respValid), .respErr(respErr), .respRdata(respRdata)
  );

  splitcnt_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .enLo(enLo), .enHi(enHi),
    .limitLo(limitLo), .limitHi(limitHi), .count(count), .state(state),
    .cycStartLo(cycStartLo), .cycStartHi(cycStartHi)
  );
endmodule

// File: tb/splitcnt_tb.sv
`timescale 1ns/1ps
module splitcnt_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0] busStrb = '0;
  logic respValid, respErr;
  logic [31:0] respRdata;
  logic enLo = 1'b0, enHi = 1'b0;
  logic [15:0] limitLo = 16'd0, limitHi = 16'd0;
  logic cycStartLo, cycStartHi;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  splitcnt_top dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busStrb(busStrb),
    .respValid(respValid), .respErr(respErr), .respRdata(respRdata),
    .enLo(enLo), .enHi(enHi), .limitLo(limitLo), .limitHi(limitHi),
    .cycStartLo(cycStartLo), .cycStartHi(cycStartHi)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic        expErr;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 32'h0,        4'h0, 1'b0, 32'h00000300}, // R1 cfg reset
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h00000000}, // R1 count reset
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000000}, // R1 state reset
    '{1'b1, 2'd1, 32'h1234ABCD, 4'hF, 1'b0, 32'h0},        // R4 full write
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h1234ABCD},
    '{1'b1, 2'd1, 32'hFFFF5555, 4'h3, 1'b0, 32'h0},        // R4 low only
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h12345555},
    '{1'b1, 2'd1, 32'h0000EE00, 4'h2, 1'b0, 32'h0},        // R4 one byte
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h1234EE55},
    '{1'b1, 2'd0, 32'h00000100, 4'h2, 1'b0, 32'h0},        // R9 lo halted, hi released
    '{1'b1, 2'd1, 32'hAAAABBBB, 4'hF, 1'b1, 32'h0},        // R5 mixed access refused
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h1234EE55}, // R5 nothing changed
    '{1'b1, 2'd1, 32'h00007777, 4'h3, 1'b0, 32'h0},        // R4 halted half alone
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h12347777},
    '{1'b1, 2'd1, 32'h99990000, 4'hC, 1'b1, 32'h0},        // R5 running hi
    '{1'b1, 2'd2, 32'h00050003, 4'hF, 1'b1, 32'h0},        // R6 state refused
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000000},
    '{1'b1, 2'd2, 32'h00000003, 4'h3, 1'b0, 32'h0},        // R6 halted lo accepted
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000003},
    '{1'b1, 2'd0, 32'h00000300, 4'h2, 1'b0, 32'h0},
    '{1'b1, 2'd2, 32'h00050003, 4'hF, 1'b0, 32'h0},        // R6 both halted
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00050003},
    '{1'b1, 2'd0, 32'h00000301, 4'h3, 1'b0, 32'h0},        // R9 unified
    '{1'b0, 2'd0, 32'h0,        4'h0, 1'b0, 32'h00000301},
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000003}, // R7 hi reads 0
    '{1'b1, 2'd2, 32'h00090004, 4'hF, 1'b0, 32'h0},
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000004},
    '{1'b1, 2'd0, 32'h00000001, 4'h2, 1'b0, 32'h0},        // release both
    '{1'b1, 2'd2, 32'h00000007, 4'hC, 1'b0, 32'h0},        // R7 hi dropped, no error
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00000004},
    '{1'b1, 2'd2, 32'h00000008, 4'h3, 1'b1, 32'h0},        // R6 lo running
    '{1'b1, 2'd1, 32'h00000000, 4'hC, 1'b1, 32'h0},        // R5 unified hi strobe
    '{1'b0, 2'd1, 32'h0,        4'h0, 1'b0, 32'h12347777},
    '{1'b1, 2'd0, 32'h00000300, 4'h3, 1'b0, 32'h0},
    '{1'b0, 2'd2, 32'h0,        4'h0, 1'b0, 32'h00050004}, // R7 hi preserved
    '{1'b1, 2'd3, 32'hFFFFFFFF, 4'hF, 1'b0, 32'h0},        // R8 unmapped write
    '{1'b0, 2'd3, 32'h0,        4'h0, 1'b0, 32'h00000000}, // R8 unmapped read
    '{1'b0, 2'd0, 32'h0,        4'h0, 1'b0, 32'h00000300}  // R8 no side effect
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [1:0] a, input logic [31:0] d,
                       input logic [3:0] s, output logic vld, output logic err,
                       output logic [31:0] rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busStrb = s;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busStrb = '0;
    vld = respValid; err = respErr; rd = respRdata;
  endtask

  task automatic wrOk(input logic [1:0] a, input logic [31:0] d, input logic [3:0] s);
    logic v, e;
    logic [31:0] r;
    busOp(1'b1, a, d, s, v, e, r);
    chk("R9 setup write accepted", {30'd0, v, e}, 32'd2);
  endtask

  task automatic rdVal(input logic [1:0] a, output logic [31:0] r);
    logic v, e;
    busOp(1'b0, a, 32'h0, 4'h0, v, e, r);
  endtask

  task automatic window(input int n, output int pl, output int ph);
    pl = 0; ph = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cycStartLo) pl++;
      if (cycStartHi) ph++;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic v, e;
    logic [31:0] r;
    int pl, ph;
    repeat (3) @(negedge clk);
    chk("R1 no response in reset", {31'd0, respValid}, 32'd0);
    rstN = 1'b1;
    chk("R1 no cycle pulses", {30'd0, cycStartHi, cycStartLo}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      busOp(VEC[k].wr, VEC[k].addr, VEC[k].data, VEC[k].strb, v, e, r);
      chk($sformatf("R9 vec %0d respValid", k), {31'd0, v}, 32'd1);
      chk($sformatf("R5/R6 vec %0d respErr", k), {31'd0, e}, {31'd0, VEC[k].expErr});
      if (!VEC[k].wr)
        chk($sformatf("R4/R7/R8 vec %0d rdata", k), r, VEC[k].expRd);
    end

    // R2: split periods, low limit 4 (period 5), high limit 2 (period 3)
    wrOk(2'd1, 32'h0, 4'hF);
    limitLo = 16'd4; limitHi = 16'd2; enLo = 1'b1; enHi = 1'b1;
    wrOk(2'd0, 32'h0, 4'h2);
    repeat (3) @(negedge clk);
    window(30, pl, ph);
    chk("R2 low pulses in 30 cycles", pl, 32'd6);
    chk("R2 high pulses in 30 cycles", ph, 32'd10);
    wrOk(2'd0, 32'h300, 4'h2);
    rdVal(2'd1, r);
    chk("R2 low within limit", {31'd0, r[15:0] <= 16'd4}, 32'd1);
    chk("R2 high within limit", {31'd0, r[31:16] <= 16'd2}, 32'd1);

    // R2: halves independent, high enable off
    wrOk(2'd1, 32'h0, 4'hF);
    enHi = 1'b0;
    wrOk(2'd0, 32'h0, 4'h2);
    repeat (3) @(negedge clk);
    window(30, pl, ph);
    chk("R2 low pulses with high idle", pl, 32'd6);
    chk("R2 high idle no pulses", ph, 32'd0);
    wrOk(2'd0, 32'h300, 4'h2);
    rdVal(2'd1, r);
    chk("R2 high half untouched", {16'd0, r[31:16]}, 32'd0);

    // R3: unified carry across bit 15
    enHi = 1'b1;
    wrOk(2'd0, 32'h301, 4'h3);
    wrOk(2'd1, 32'h0000FFFE, 4'hF);
    limitHi = 16'd1; limitLo = 16'd3;
    wrOk(2'd0, 32'h001, 4'h2);
    repeat (2) @(negedge clk);
    wrOk(2'd0, 32'h301, 4'h2);
    rdVal(2'd1, r);
    chk("R3 carry into upper half", {16'd0, r[31:16]}, 32'd1);
    chk("R3 lower bits small after carry", {31'd0, r[15:0] <= 16'd3}, 32'd1);

    // R3: unified wrap at {limitHi,limitLo}, low pulse only
    wrOk(2'd1, 32'h0000FFFE, 4'hF);
    wrOk(2'd0, 32'h001, 4'h2);
    window(20, pl, ph);
    chk("R3 one unified wrap pulse", pl, 32'd1);
    chk("R3 no high pulse in unified", ph, 32'd0);
    wrOk(2'd0, 32'h301, 4'h2);
    rdVal(2'd1, r);
    chk("R3 upper zero after wrap", {16'd0, r[31:16]}, 32'd0);

    finishRun();
  end
endmodule